// File: doc/BRIEF.md
# Serial Transmitter with Break Sequencing

This block serialises bytes onto an asynchronous line that idles high. A single holding register accepts one byte from the host while the previous byte is still being shifted out. The next frame therefore follows the last stop bit with no gap. A clock-enable input sets the bit rate. Each bit lasts either sixteen enables or a single enable, as selected by a mode input. Another input selects one or two stop bits.

Strobe inputs control the block:
- Enable and disable strobes gate the transmitter. Disabling it lets queued data finish and does not cut a frame short.
- A start-break strobe holds the line low (spacing). A stop-break strobe releases it. Both are ordered against any characters that are still queued.
- A reset strobe returns the block at once to the disabled, idle state.

Two status outputs tell the host when it may write and when the transmitter has fully drained.

Top module: `uart_tx_brk`

## Requirements
- R1: After `rst_ni` is released, `txd_o` is high and `tx_rdy_o` and `tx_emt_o` are low. The transmitter starts out disabled.
- R2: `tx_rdy_o` is high exactly when the transmitter is enabled and the holding register is empty. An enable strobe with an empty holding register raises `tx_rdy_o` in the next cycle. A write (`wr_i`) is accepted only while `tx_rdy_o` is high; at any other time it is ignored and nothing is transmitted.
- R3: A frame has these parts, in order:
  - a low start bit;
  - the 8 data bits, least significant bit first;
  - high stop bits.
  Each bit lasts 16 clock enables when `x1_mode_i`=0 and 1 clock enable when `x1_mode_i`=1. `txd_o` changes only at bit boundaries, except on a reset strobe.
- R4: `two_stop_i`=0 gives one stop bit and `two_stop_i`=1 gives two. Back-to-back frames therefore start exactly 10 or 11 bit times apart.
- R5: A byte written while another is being shifted out starts right after that frame's last stop bit. `tx_emt_o` is high only when `tx_rdy_o` is high and no frame or break is on the line.
- R6: A disable strobe drops `tx_rdy_o` and `tx_emt_o` in the next cycle. The frame being shifted and the byte in the holding register are still sent in full.
- R7: A start-break strobe has no effect while the transmitter is disabled. Enabling the transmitter later does not start a break.
- R8: If the transmitter is enabled and idle, a start-break strobe drives `txd_o` low within two bit times. The line stays low until a stop-break strobe.
- R9: If characters are being shifted or are queued when a start-break strobe arrives, the break starts only after all of them have been sent. This includes bytes written after the strobe.
- R10: A stop-break strobe returns `txd_o` high within two bit times. The line stays high for at least one bit time before the next start bit.
- R11: A reset strobe (`rst_cmd_i`) makes `txd_o` high and `tx_rdy_o` and `tx_emt_o` low in the next cycle. It disables the transmitter and drops the queued byte and any pending or active break, so nothing further is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Bit-rate clock enable |
| x1_mode_i | input | 1 | 1: one enable per bit; 0: sixteen enables per bit |
| two_stop_i | input | 1 | 1: two stop bits; 0: one |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| en_cmd_i | input | 1 | Enable-transmitter strobe |
| dis_cmd_i | input | 1 | Disable-transmitter strobe (drains queued data) |
| rst_cmd_i | input | 1 | Immediate transmitter reset strobe |
| brk_on_i | input | 1 | Start-break strobe |
| brk_off_i | input | 1 | Stop-break strobe |
| txd_o | output | 1 | Serial line, idles high |
| tx_rdy_o | output | 1 | Holding register can accept a byte |
| tx_emt_o | output | 1 | Transmitter enabled and fully drained |

## Verification
The hardest state to reach is a break that is requested while one byte is being shifted and a second is queued, with a third byte written after the request. The bench reaches it by forking a writer against a line decoder. The writer issues the start-break strobe as soon as the second byte is accepted, then waits on `tx_rdy_o` to push the third. The decoder checks that all three frames appear intact before the line falls. The stop-break path then continues from that break with a byte already waiting. Timing is checked by counting cycles from the strobe to the line release and from the release to the next start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK,
    ST_MARK
  } tx_state_e;
endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic x1_i,
  output logic tick_o
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (x1_i || (cnt_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (clr_i) begin
      full_o <= 1'b0;
    end else if (wr_i) begin
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end else if (load_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              two_stop_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              brk_pend_i,
  output logic              load_o,
  output logic              idle_o,
  output logic              txd_o
);
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [BC_W-1:0]   bcnt_q;
  logic              extra_stop_q;
  logic              frame_end;
  logic              decide;

  // frame boundary: pick next char, then break, then idle
  assign frame_end = (state_q == ST_STOP) && !extra_stop_q;
  assign decide    = tick_i && !clr_i &&
                     (state_q == ST_IDLE || state_q == ST_MARK || frame_end);
  assign load_o    = decide && hold_full_i;
  assign idle_o    = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      shreg_q      <= '0;
      bcnt_q       <= '0;
      extra_stop_q <= 1'b0;
      txd_o        <= 1'b1;
    end else if (clr_i) begin
      state_q      <= ST_IDLE;
      extra_stop_q <= 1'b0;
      txd_o        <= 1'b1;
    end else if (decide) begin
      if (hold_full_i) begin
        state_q <= ST_START;
        shreg_q <= hold_data_i;
        txd_o   <= 1'b0;
      end else if (brk_pend_i) begin
        state_q <= ST_BREAK;
        txd_o   <= 1'b0;
      end else begin
        state_q <= ST_IDLE;
        txd_o   <= 1'b1;
      end
    end else if (tick_i) begin
      case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          txd_o   <= shreg_q[0];
          shreg_q <= shreg_q >> 1;
          bcnt_q  <= BC_W'(DATA_W - 1);
        end
        ST_DATA: begin
          if (bcnt_q == '0) begin
            state_q      <= ST_STOP;
            txd_o        <= 1'b1;
            extra_stop_q <= two_stop_i;
          end else begin
            txd_o   <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            bcnt_q  <= bcnt_q - 1'b1;
          end
        end
        ST_STOP:  extra_stop_q <= 1'b0;
        ST_BREAK: begin
          if (!brk_pend_i) begin
            state_q <= ST_MARK;
            txd_o   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              x1_mode_i,
  input  logic              two_stop_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              en_cmd_i,
  input  logic              dis_cmd_i,
  input  logic              rst_cmd_i,
  input  logic              brk_on_i,
  input  logic              brk_off_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_emt_o
);
  logic              enabled_q;
  logic              brk_pend_q;
  logic              bit_tick;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              line_idle;
  logic              wr_accept;

  assign tx_rdy_o  = enabled_q && !hold_full;
  assign tx_emt_o  = tx_rdy_o && line_idle;
  assign wr_accept = wr_i && tx_rdy_o;

  // reset > disable > enable; stop-break wins over start-break
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enabled_q  <= 1'b0;
      brk_pend_q <= 1'b0;
    end else if (rst_cmd_i) begin
      enabled_q  <= 1'b0;
      brk_pend_q <= 1'b0;
    end else begin
      if (dis_cmd_i)     enabled_q <= 1'b0;
      else if (en_cmd_i) enabled_q <= 1'b1;
      if (brk_off_i)                   brk_pend_q <= 1'b0;
      else if (brk_on_i && enabled_q)  brk_pend_q <= 1'b1;
    end
  end

  uart_tx_bit_timer #(
    .OVERSAMPLE(OVERSAMPLE)
  ) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rst_cmd_i),
    .en_i  (clk_en_i),
    .x1_i  (x1_mode_i),
    .tick_o(bit_tick)
  );

  uart_tx_hold #(
    .DATA_W(DATA_W)
  ) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rst_cmd_i),
    .wr_i     (wr_accept),
    .wr_data_i(wr_data_i),
    .load_i   (load),
    .full_o   (hold_full),
    .data_o   (hold_data)
  );

  uart_tx_framer #(
    .DATA_W(DATA_W)
  ) i_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rst_cmd_i),
    .tick_i     (bit_tick),
    .two_stop_i (two_stop_i),
    .hold_full_i(hold_full),
    .hold_data_i(hold_data),
    .brk_pend_i (brk_pend_q),
    .load_o     (load),
    .idle_o     (line_idle),
    .txd_o      (txd_o)
  );
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              en_cmd_i,
  input logic              dis_cmd_i,
  input logic              rst_cmd_i,
  input logic              txd_o,
  input logic              tx_rdy_o,
  input logic              tx_emt_o,
  input logic              bit_tick,
  input logic              hold_full,
  input logic [DATA_W-1:0] hold_data
);
  a_r3_txd_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick && !rst_cmd_i) |=> $stable(txd_o));

  a_r11_reset_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_i |=> (txd_o && !tx_rdy_o && !tx_emt_o));

  a_r5_emt_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_emt_o |-> tx_rdy_o);

  a_r2_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tx_rdy_o && !rst_cmd_i) |=> $stable(hold_data));

  a_r2_enable_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_cmd_i && !dis_cmd_i && !rst_cmd_i && !hold_full && !wr_i) |=> tx_rdy_o);

  a_r6_disable_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_cmd_i |=> (!tx_rdy_o && !tx_emt_o));
endmodule

bind uart_tx_brk uart_tx_brk_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_uart_tx_brk.sv
`timescale 1ns/1ps
module test_uart_tx_brk;
  localparam int C_EN = 0, C_DIS = 1, C_RST = 2, C_BON = 3, C_BOFF = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_en_i;
  logic x1_mode_i = 1'b1;
  logic two_stop_i = 1'b0;
  logic wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic en_cmd_i = 1'b0, dis_cmd_i = 1'b0, rst_cmd_i = 1'b0;
  logic brk_on_i = 1'b0, brk_off_i = 1'b0;
  logic txd_o, tx_rdy_o, tx_emt_o;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  int en_div = 4;
  int bt = 4;
  int div_q = 0;

  logic [7:0] ra, rb, rc;
  longint ta, tb, tc;
  bit oka, okb, okc;
  int lows;

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    div_q <= (div_q >= en_div - 1) ? 0 : div_q + 1;
  end
  assign clk_en_i = (div_q == 0);

  uart_tx_brk i_uart_tx_brk (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i),
    .x1_mode_i(x1_mode_i), .two_stop_i(two_stop_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i),
    .en_cmd_i(en_cmd_i), .dis_cmd_i(dis_cmd_i), .rst_cmd_i(rst_cmd_i),
    .brk_on_i(brk_on_i), .brk_off_i(brk_off_i),
    .txd_o(txd_o), .tx_rdy_o(tx_rdy_o), .tx_emt_o(tx_emt_o)
  );

  task automatic chk(input bit c, input string req, input longint act, input longint exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input int c);
    case (c)
      C_EN:    en_cmd_i  = 1'b1;
      C_DIS:   dis_cmd_i = 1'b1;
      C_RST:   rst_cmd_i = 1'b1;
      C_BON:   brk_on_i  = 1'b1;
      default: brk_off_i = 1'b1;
    endcase
    @(negedge clk_i);
    en_cmd_i = 0; dis_cmd_i = 0; rst_cmd_i = 0; brk_on_i = 0; brk_off_i = 0;
  endtask

  task automatic force_write(input logic [7:0] d);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    int g = 0;
    while (!tx_rdy_o && g < 100 * bt) begin @(negedge clk_i); g++; end
    force_write(d);
  endtask

  task automatic rx(output logic [7:0] d, output longint ts, output bit ok);
    int g = 0;
    d = '0; ok = 1'b0; ts = 0;
    while (txd_o !== 1'b0 && g < 60 * bt) begin @(negedge clk_i); g++; end
    if (txd_o !== 1'b0) return;
    ts = cyc;
    step(bt / 2);
    ok = (txd_o == 1'b0);
    for (int i = 0; i < 8; i++) begin step(bt); d[i] = txd_o; end
    step(bt); ok &= (txd_o == 1'b1);
    if (two_stop_i) begin step(bt); ok &= (txd_o == 1'b1); end
  endtask

  task automatic quiet(input int n, output int l);
    l = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk_i); if (txd_o == 1'b0) l++; end
  endtask

  task automatic set_mode(input bit x1, input int div, input bit two);
    x1_mode_i = x1; en_div = div; two_stop_i = two;
    bt = x1 ? div : div * 16;
    pulse(C_RST);
    pulse(C_EN);
  endtask

  always @(posedge clk_i) begin
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    chk(txd_o == 1 && tx_rdy_o == 0 && tx_emt_o == 0, "R1 reset state",
        {txd_o, tx_rdy_o, tx_emt_o}, 3'b100);

    // R2: write while disabled is dropped
    force_write(8'h3C);
    quiet(14 * bt, lows);
    chk(lows == 0, "R2 write while disabled", lows, 0);

    pulse(C_EN);
    chk(tx_rdy_o == 1 && tx_emt_o == 1, "R2 enable raises ready", {tx_rdy_o, tx_emt_o}, 2'b11);

    // R3 sweep: 1X mode, all byte values
    for (int b = 0; b < 256; b++) begin
      fork
        send(8'(b));
        rx(ra, ta, oka);
      join
      chk(oka && ra == 8'(b), "R3 1X frame", ra, b);
    end

    // R3: 16X mode selected patterns
    set_mode(1'b0, 1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      fork
        send(8'(k * 37 + 1));
        rx(ra, ta, oka);
      join
      chk(oka && ra == 8'(k * 37 + 1), "R3 16X frame", ra, k * 37 + 1);
    end

    // R4/R5: back-to-back spacing, 16X two stop bits
    set_mode(1'b0, 1, 1'b1);
    fork
      begin send(8'hA5); send(8'h5A); end
      begin rx(ra, ta, oka); rx(rb, tb, okb); end
    join
    chk(oka && okb && ra == 8'hA5 && rb == 8'h5A, "R5 queued byte", rb, 8'h5A);
    chk(tb - ta == 11 * bt, "R4 16X two-stop spacing", tb - ta, 11 * bt);

    set_mode(1'b1, 4, 1'b1);
    fork
      begin send(8'h81); send(8'h7E); end
      begin rx(ra, ta, oka); rx(rb, tb, okb); end
    join
    chk(oka && okb && rb == 8'h7E, "R4 1X two-stop data", rb, 8'h7E);
    chk(tb - ta == 11 * bt, "R4 1X two-stop spacing", tb - ta, 11 * bt);

    set_mode(1'b1, 4, 1'b0);
    fork
      begin send(8'h11); send(8'h22); end
      begin
        rx(ra, ta, oka);
        rx(rb, tb, okb);
      end
    join
    chk(tb - ta == 10 * bt, "R4 1X one-stop spacing", tb - ta, 10 * bt);

    // R5: emt low while shifting, high after drain
    fork
      send(8'hC3);
      rx(ra, ta, oka);
      begin
        step(4 * bt);
        chk(tx_rdy_o == 1 && tx_emt_o == 0, "R5 emt low while shifting",
            {tx_rdy_o, tx_emt_o}, 2'b10);
      end
    join
    step(bt);
    chk(tx_emt_o == 1, "R5 emt after drain", tx_emt_o, 1);

    // R2: write into full holding register dropped
    fork
      begin send(8'h44); send(8'h55); force_write(8'h66); end
      begin rx(ra, ta, oka); rx(rb, tb, okb); end
    join
    chk(oka && okb && ra == 8'h44 && rb == 8'h55, "R2 queued pair", rb, 8'h55);
    quiet(14 * bt, lows);
    chk(lows == 0, "R2 write when full ignored", lows, 0);

    // R6: disable drains
    fork
      begin
        send(8'h96); send(8'h69); pulse(C_DIS);
        chk(tx_rdy_o == 0 && tx_emt_o == 0, "R6 disable status", {tx_rdy_o, tx_emt_o}, 0);
      end
      begin rx(ra, ta, oka); rx(rb, tb, okb); end
    join
    chk(oka && ra == 8'h96, "R6 drain active char", ra, 8'h96);
    chk(okb && rb == 8'h69, "R6 drain queued char", rb, 8'h69);

    // R7: break while disabled ignored
    pulse(C_BON);
    quiet(4 * bt, lows);
    chk(lows == 0, "R7 break while disabled", lows, 0);
    pulse(C_EN);
    quiet(4 * bt, lows);
    chk(lows == 0, "R7 no break after enable", lows, 0);

    // R8: idle break
    begin
      int n = 0;
      pulse(C_BON);
      while (txd_o == 1'b1 && n < 10 * bt) begin @(negedge clk_i); n++; end
      chk(n <= 2 * bt, "R8 idle break delay", n, 2 * bt);
      quiet(6 * bt, lows);
      chk(lows == 6 * bt, "R8 break held low", lows, 6 * bt);
      pulse(C_BOFF);
      n = 0;
      while (txd_o == 1'b0 && n < 10 * bt) begin @(negedge clk_i); n++; end
      chk(txd_o == 1, "R10 idle break release", txd_o, 1);
      step(2 * bt);
    end

    // R9: break after active, queued and later-written chars
    fork
      begin send(8'h12); send(8'h34); pulse(C_BON); send(8'h56); end
      begin
        rx(ra, ta, oka); rx(rb, tb, okb); rx(rc, tc, okc);
        step(bt);
        chk(txd_o == 0, "R9 break after queue", txd_o, 0);
      end
    join
    chk(oka && okb && okc && ra == 8'h12 && rb == 8'h34 && rc == 8'h56,
        "R9 chars before break", rc, 8'h56);
    quiet(3 * bt, lows);
    chk(lows == 3 * bt, "R9 break holds", lows, 3 * bt);

    // R10: stop break with a byte waiting
    begin
      int n = 0;
      longint th;
      send(8'hE7);
      pulse(C_BOFF);
      n = 1;
      while (txd_o == 1'b0 && n < 10 * bt) begin @(negedge clk_i); n++; end
      chk(txd_o == 1 && n <= 2 * bt, "R10 release delay", n, 2 * bt);
      th = cyc;
      rx(ra, ta, oka);
      chk(ta - th >= bt, "R10 mark before char", ta - th, bt);
      chk(oka && ra == 8'hE7, "R10 char after break", ra, 8'hE7);
      step(2 * bt);
    end

    // R11: reset command mid-frame with queued byte and pending break
    send(8'h0F);
    while (txd_o == 1'b1) @(negedge clk_i);
    send(8'hF0);
    pulse(C_BON);
    step(2 * bt);
    pulse(C_RST);
    chk(txd_o == 1 && tx_rdy_o == 0 && tx_emt_o == 0, "R11 reset command",
        {txd_o, tx_rdy_o, tx_emt_o}, 3'b100);
    quiet(14 * bt, lows);
    chk(lows == 0, "R11 queue dropped", lows, 0);
    pulse(C_EN);
    quiet(6 * bt, lows);
    chk(lows == 0 && tx_emt_o == 1, "R11 break cancelled", lows, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule